// File: doc/BRIEF.md
# Protection Fault Supervisor

This block is the supervisor of a primary-side LED driver controller. It reads three supply comparator levels and a set of protection flags, and it decides whether the controller is in logic reset, stopped, switching, discharging its supply, waiting out a long auto-restart delay, or latched off. From that decision it drives the gate-drive enable, a start-up current select, a low-consumption current select and a soft-start indicator.

Faults fall into three classes:

- **Discharge class.** Line brown-out, thermal shutdown and a shorted current-sense pin send the controller to supply discharge. It leaves that state when the supply drops below its turn-off level or when the brown-out flag clears.
- **Timer class.** Supply overvoltage always starts the auto-restart delay.
- **Latch class.** A winding or output-diode short, and an auxiliary-winding short, are handled by a build-time parameter. The latched build holds the controller off until the supply falls below the deep logic-reset level. The auto-restart build treats them like overvoltage.

The block also contains the timer that turns a raw zero-crossing short comparator into a confirmed auxiliary short. Every timer counts ticks of a shared prescaler and clears when its enabling state or condition goes away.

The state encoding used internally is: reset 0, stop 1, run 2, discharge 3, recovery wait 4, latch 5.

Top module: `fault_supervisor`

## Requirements
- R1: After `rst_n` is released the block is in the reset state. In that state `startup_sel_o` is 1 and `drv_en_o`, `ss_active_o` and `lowcur_sel_o` are 0.
- R2: The reset state is held while `vcc_above_on_i` is 0. When it is 1, the block moves to stop on the next clock, where all four outputs are 0. From stop it moves to run on the next clock if no fault flag is set.
- R3: `drv_en_o` is 1 only in the run state. At most one of `drv_en_o`, `startup_sel_o` and `lowcur_sel_o` is 1 at any time.
- R4: `bo_nok_i`, `tsd_i` or `cs_short_i` seen in stop or run moves the block to discharge. In discharge `lowcur_sel_o` is 1 and `drv_en_o` is 0. The block stays there after the flag clears.
- R5: Discharge returns to reset on the clock after `vcc_below_off_i` is 1, or after `bo_nok_i` changes from 1 to 0.
- R6: `vcc_ovp_i` in stop or run moves both variants to the recovery wait, in which all outputs are 0.
- R7: The recovery wait lasts RECOVERY_TICKS prescaler ticks and then returns to reset. The input that caused it need not stay asserted.
- R8: For the first SOFTSTART_TICKS ticks of each run entry, `ss_active_o` is 1 alongside `drv_en_o`. After that it is 0.
- R9: `wod_short_i` in stop or run enters the latch state when LATCHED=1, and the recovery wait when LATCHED=0. The latch state ignores expiry of the recovery delay and all fault inputs.
- R10: `vcc_below_rst_i` moves the block to reset on the next clock from any state. It is the only way out of the latch state.
- R11: `zcd_short_i` held for ZSHORT_TICKS consecutive ticks in run is a confirmed auxiliary short, handled like R9. A shorter assertion has no effect.
- R12: When faults of several classes are present together, the latch class wins over the timer class, and the timer class wins over the discharge class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on_i | input | 1 | Supply above start-up level |
| vcc_below_off_i | input | 1 | Supply below turn-off level |
| vcc_below_rst_i | input | 1 | Supply below deep logic-reset level |
| bo_nok_i | input | 1 | Line brown-out flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| cs_short_i | input | 1 | Current-sense pin short flag |
| vcc_ovp_i | input | 1 | Supply overvoltage flag |
| wod_short_i | input | 1 | Winding or output-diode short flag |
| zcd_short_i | input | 1 | Raw zero-crossing short comparator |
| drv_en_o | output | 1 | Gate-drive enable |
| ss_active_o | output | 1 | Soft-start phase active |
| startup_sel_o | output | 1 | Start-up supply current select |
| lowcur_sel_o | output | 1 | Low-consumption supply current select |

## Verification
The properties assume that every flag is already synchronous to `clk` and free of glitches. They also assume that a fall of `bo_nok_i` is meaningful one sample after it happens, since both the design and the discharge-hold property compare against the previous clock's value. The stimulus changes inputs only on falling clock edges and holds each pattern for at least one full cycle. It never drives contradictory supply levels for longer than the transition under test. Both variants receive identical stimulus, so every check shows where their behaviour is expected to differ.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    FS_RESET = 3'd0,
    FS_STOP  = 3'd1,
    FS_RUN   = 3'd2,
    FS_DISCH = 3'd3,
    FS_RECOV = 3'd4,
    FS_LATCH = 3'd5
  } fs_state_e;
endpackage

// File: rtl/fs_prescaler.sv
module fs_prescaler #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + W'(1);
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/fs_tick_timer.sv
module fs_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt;

  // Counter clears the moment its enable drops and saturates at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!en)                cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + W'(1);
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter bit LATCHED = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vcc_above_on,
  input  logic      vcc_below_off,
  input  logic      vcc_below_rst,
  input  logic      bo_nok,
  input  logic      tsd,
  input  logic      cs_short,
  input  logic      vcc_ovp,
  input  logic      wod_short,
  input  logic      aux_short,
  input  logic      recov_done,
  output fs_state_e state
);
  fs_state_e nxt;
  logic      bo_q;
  logic      bo_fell;
  logic      severe;
  logic      latch_cls;
  logic      timer_cls;
  logic      disch_cls;

  assign bo_fell   = bo_q && !bo_nok;
  assign severe    = wod_short || aux_short;
  assign latch_cls = LATCHED && severe;
  assign timer_cls = vcc_ovp || (!LATCHED && severe);
  assign disch_cls = bo_nok || tsd || cs_short;

  always_comb begin
    nxt = state;
    if (vcc_below_rst) begin
      nxt = FS_RESET;
    end else begin
      unique case (state)
        FS_RESET: if (vcc_above_on) nxt = FS_STOP;
        FS_STOP, FS_RUN: begin
          if (latch_cls)      nxt = FS_LATCH;
          else if (timer_cls) nxt = FS_RECOV;
          else if (disch_cls) nxt = FS_DISCH;
          else                nxt = FS_RUN;
        end
        FS_DISCH: if (vcc_below_off || bo_fell) nxt = FS_RESET;
        FS_RECOV: if (recov_done) nxt = FS_RESET;
        FS_LATCH: nxt = FS_LATCH;
        default:  nxt = FS_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_RESET;
      bo_q  <= 1'b0;
    end else begin
      state <= nxt;
      bo_q  <= bo_nok;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter bit          LATCHED         = 1'b0,
  parameter int unsigned TICK_DIV        = 50,
  parameter int unsigned RECOVERY_TICKS  = 4000000,
  parameter int unsigned ZSHORT_TICKS    = 90000,
  parameter int unsigned SOFTSTART_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_on_i,
  input  logic vcc_below_off_i,
  input  logic vcc_below_rst_i,
  input  logic bo_nok_i,
  input  logic tsd_i,
  input  logic cs_short_i,
  input  logic vcc_ovp_i,
  input  logic wod_short_i,
  input  logic zcd_short_i,
  output logic drv_en_o,
  output logic ss_active_o,
  output logic startup_sel_o,
  output logic lowcur_sel_o
);
  fs_state_e cur_state;
  logic      tick;
  logic      aux_short;
  logic      recov_done;
  logic      ss_done;
  logic      in_run;

  assign in_run = (cur_state == FS_RUN);

  fs_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  fs_tick_timer #(.LIMIT(ZSHORT_TICKS)) u_aux_tmr (
    .clk(clk), .rst_n(rst_n), .en(in_run && zcd_short_i),
    .tick(tick), .done(aux_short)
  );

  fs_tick_timer #(.LIMIT(RECOVERY_TICKS)) u_rec_tmr (
    .clk(clk), .rst_n(rst_n), .en(cur_state == FS_RECOV),
    .tick(tick), .done(recov_done)
  );

  fs_tick_timer #(.LIMIT(SOFTSTART_TICKS)) u_ss_tmr (
    .clk(clk), .rst_n(rst_n), .en(in_run),
    .tick(tick), .done(ss_done)
  );

  fs_ctrl #(.LATCHED(LATCHED)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_on(vcc_above_on_i), .vcc_below_off(vcc_below_off_i),
    .vcc_below_rst(vcc_below_rst_i), .bo_nok(bo_nok_i), .tsd(tsd_i),
    .cs_short(cs_short_i), .vcc_ovp(vcc_ovp_i), .wod_short(wod_short_i),
    .aux_short(aux_short), .recov_done(recov_done), .state(cur_state)
  );

  assign drv_en_o      = in_run;
  assign ss_active_o   = in_run && !ss_done;
  assign startup_sel_o = (cur_state == FS_RESET);
  assign lowcur_sel_o  = (cur_state == FS_DISCH);
endmodule

// File: rtl/fs_checker.sv
module fs_checker
  import fs_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      vcc_above_on_i,
  input logic      vcc_below_off_i,
  input logic      vcc_below_rst_i,
  input logic      bo_nok_i,
  input logic      vcc_ovp_i,
  input logic      drv_en_o,
  input logic      ss_active_o,
  input logic      startup_sel_o,
  input logic      lowcur_sel_o,
  input fs_state_e cur_state
);
  a_r3_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_en_o, startup_sel_o, lowcur_sel_o}));

  a_r2_wait_on: assert property (@(posedge clk) disable iff (!rst_n)
    startup_sel_o && !vcc_above_on_i |=> startup_sel_o);

  a_r4_disch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lowcur_sel_o && !vcc_below_off_i && !vcc_below_rst_i && !$fell(bo_nok_i)
      |=> lowcur_sel_o);

  a_r6_ovp_stop: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o && vcc_ovp_i && !vcc_below_rst_i |=> !drv_en_o && !lowcur_sel_o);

  a_r8_ss_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active_o |-> drv_en_o);

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == FS_LATCH) && !vcc_below_rst_i |=> (cur_state == FS_LATCH));

  a_r10_deep_reset: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_below_rst_i |=> startup_sel_o);
endmodule

bind fault_supervisor fs_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .vcc_above_on_i(vcc_above_on_i), .vcc_below_off_i(vcc_below_off_i),
  .vcc_below_rst_i(vcc_below_rst_i), .bo_nok_i(bo_nok_i),
  .vcc_ovp_i(vcc_ovp_i), .drv_en_o(drv_en_o), .ss_active_o(ss_active_o),
  .startup_sel_o(startup_sel_o), .lowcur_sel_o(lowcur_sel_o),
  .cur_state(cur_state)
);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int REC = 20;
  localparam int ZS  = 10;
  localparam int SS  = 4;

  // Expected output codes {drv, ss, startup, lowcur}
  localparam logic [3:0] O_RST = 4'b0010;
  localparam logic [3:0] O_OFF = 4'b0000;
  localparam logic [3:0] O_SS  = 4'b1100;
  localparam logic [3:0] O_RUN = 4'b1000;
  localparam logic [3:0] O_DIS = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic von = 0, voff = 0, vrst = 0, bo = 0, tsd = 0, css = 0, ovp = 0, wod = 0, zcd = 0;
  logic drv0, ss0, st0, lc0, drv1, ss1, st1, lc1;

  always #10 clk = ~clk;

  fault_supervisor #(.LATCHED(1'b0), .TICK_DIV(1), .RECOVERY_TICKS(REC),
                     .ZSHORT_TICKS(ZS), .SOFTSTART_TICKS(SS)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_above_on_i(von), .vcc_below_off_i(voff),
    .vcc_below_rst_i(vrst), .bo_nok_i(bo), .tsd_i(tsd), .cs_short_i(css),
    .vcc_ovp_i(ovp), .wod_short_i(wod), .zcd_short_i(zcd),
    .drv_en_o(drv0), .ss_active_o(ss0), .startup_sel_o(st0), .lowcur_sel_o(lc0));

  fault_supervisor #(.LATCHED(1'b1), .TICK_DIV(1), .RECOVERY_TICKS(REC),
                     .ZSHORT_TICKS(ZS), .SOFTSTART_TICKS(SS)) u1 (
    .clk(clk), .rst_n(rst_n), .vcc_above_on_i(von), .vcc_below_off_i(voff),
    .vcc_below_rst_i(vrst), .bo_nok_i(bo), .tsd_i(tsd), .cs_short_i(css),
    .vcc_ovp_i(ovp), .wod_short_i(wod), .zcd_short_i(zcd),
    .drv_en_o(drv1), .ss_active_o(ss1), .startup_sel_o(st1), .lowcur_sel_o(lc1));

  typedef struct {
    logic [3:0] e0;
    logic [3:0] e1;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  // Monitor: compares queued expectations against both variants.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_chk++;
      if ({drv0, ss0, st0, lc0} !== it.e0) begin
        n_bad++;
        $display("FAIL %s auto variant: got %b expected %b", it.tag, {drv0, ss0, st0, lc0}, it.e0);
      end
      n_chk++;
      if ({drv1, ss1, st1, lc1} !== it.e1) begin
        n_bad++;
        $display("FAIL %s latched variant: got %b expected %b", it.tag, {drv1, ss1, st1, lc1}, it.e1);
      end
    end
  end

  // Driver: wait n edges, queue the expectation, return at the falling edge.
  task automatic chk(input int n, input logic [3:0] e0, input logic [3:0] e1, input string tag);
    repeat (n) @(posedge clk);
    q.push_back('{e0, e1, tag});
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(1, O_RST, O_RST, "R1 reset state");
    chk(3, O_RST, O_RST, "R2 hold reset without start level");
    von = 1;
    chk(1, O_OFF, O_OFF, "R2 stop state");
    chk(1, O_SS,  O_SS,  "R3 run with soft-start");
    chk(3, O_SS,  O_SS,  "R8 soft-start still active");
    chk(1, O_RUN, O_RUN, "R8 soft-start over");

    // Brown-out: discharge, then exit on its fall
    bo = 1;
    chk(1, O_DIS, O_DIS, "R4 brown-out to discharge");
    chk(5, O_DIS, O_DIS, "R4 discharge held");
    bo = 0;
    chk(1, O_RST, O_RST, "R5 brown-out fall exits discharge");
    chk(1, O_OFF, O_OFF, "R2 stop after restart");
    chk(1, O_SS,  O_SS,  "R8 soft-start after restart");
    chk(4, O_RUN, O_RUN, "R8 full drive after restart");

    // Thermal: discharge, exit on supply turn-off level
    tsd = 1;
    chk(1, O_DIS, O_DIS, "R4 thermal to discharge");
    tsd = 0;
    chk(2, O_DIS, O_DIS, "R4 discharge survives flag clear");
    voff = 1;
    chk(1, O_RST, O_RST, "R5 turn-off level exits discharge");
    voff = 0;
    chk(1, O_OFF, O_OFF, "R2 stop");
    chk(1, O_SS,  O_SS,  "R3 run");
    chk(4, O_RUN, O_RUN, "R8 full drive");

    // Overvoltage: recovery wait in both variants
    ovp = 1;
    chk(1, O_OFF, O_OFF, "R6 overvoltage stops drive");
    ovp = 0;
    chk(REC - 1, O_OFF, O_OFF, "R7 recovery wait not expired");
    chk(2, O_RST, O_RST, "R7 recovery wait expiry to reset");
    chk(1, O_OFF, O_OFF, "R2 stop");
    chk(1, O_SS,  O_SS,  "R3 run");
    chk(4, O_RUN, O_RUN, "R8 full drive");

    // Winding short: variants diverge
    wod = 1;
    chk(1, O_OFF, O_OFF, "R9 winding short stops drive");
    wod = 0;
    chk(REC, O_OFF, O_OFF, "R9 waiting");
    chk(1, O_RST, O_OFF, "R9 auto restarts, latched holds");
    chk(1, O_OFF, O_OFF, "R9 stop vs latch");
    chk(1, O_SS,  O_OFF, "R9 run vs latch");
    chk(4, O_RUN, O_OFF, "R9 latch ignores timers");
    vrst = 1;
    chk(1, O_RST, O_RST, "R10 deep reset from run and latch");
    vrst = 0;
    chk(1, O_OFF, O_OFF, "R10 stop after deep reset");
    chk(1, O_SS,  O_SS,  "R10 run after deep reset");
    chk(4, O_RUN, O_RUN, "R8 full drive");

    // Zero-crossing short: short pulse ignored, sustained confirmed
    zcd = 1;
    chk(ZS - 2, O_RUN, O_RUN, "R11 short pulse running");
    zcd = 0;
    chk(1, O_RUN, O_RUN, "R11 short pulse ignored");
    zcd = 1;
    chk(ZS, O_RUN, O_RUN, "R11 not yet confirmed");
    chk(1, O_OFF, O_OFF, "R11 confirmed aux short");
    zcd = 0;
    chk(REC + 1, O_RST, O_OFF, "R11 auto restarts, latched holds");
    chk(2, O_SS, O_OFF, "R11 auto back in run");

    vrst = 1;
    chk(1, O_RST, O_RST, "R10 deep reset");
    vrst = 0;
    chk(1, O_OFF, O_OFF, "R2 stop");
    chk(1, O_SS,  O_SS,  "R3 run");
    chk(4, O_RUN, O_RUN, "R8 full drive");

    // Priority: latch/timer class beats discharge class
    bo = 1;
    wod = 1;
    chk(1, O_OFF, O_OFF, "R12 severe fault wins over brown-out");
    chk(3, O_OFF, O_OFF, "R12 no discharge current");

    // Discharge entered from stop
    vrst = 1;
    bo = 0;
    wod = 0;
    css = 1;
    chk(1, O_RST, O_RST, "R10 deep reset");
    vrst = 0;
    chk(1, O_OFF, O_OFF, "R2 stop with fault present");
    chk(1, O_DIS, O_DIS, "R4 sense short from stop");
    css = 0;
    voff = 1;
    chk(1, O_RST, O_RST, "R5 exit discharge");
    voff = 0;
    @(negedge clk);
    finish_run();
  end
endmodule